// File: doc/BRIEF.md
# Multi-Width Integer ALU with Condition Flags

This block is a purely combinational integer arithmetic and logic unit for an execution pipeline. It accepts two 64-bit operands and a 4-bit operation code. A two-bit size select picks an operand width of 8, 16, 32 or 64 bits. It returns a result that is zero-extended above the selected width. It also returns four condition flags: carry, zero, sign and overflow, all evaluated at that width. Bits of the operands above the selected width are ignored.

Beside the values, the block states which architectural state the operation may change. One enable says whether the result is to be written back, and one enable per flag says whether that flag is to be updated. The surrounding pipeline commits only what is enabled, and it keeps the old value of any flag whose enable is low. A separate unary input reuses the two low bits of the operation code for increment, decrement, bitwise not and negate. Rotate codes are reported as unsupported.

Top module: `flagAlu`

## Requirements
- R1: With unaryOp low, opCode selects the operation: 0 add, 1 or, 2 add-with-carry, 3 subtract-with-borrow, 4 and, 5 subtract, 6 xor, 7 compare, 8 to B rotates, C shift left, D logical shift right, E test, F arithmetic shift right. sizeSel 0/1/2/3 selects 8/16/32/64 bits. For add, CF is set when the unsigned sum at the width reaches 2^width. OF is set when the signed sum does not fit the width.
- R2: For subtract and compare, CF is set when a < b as unsigned values at the width. OF is set when the signed difference does not fit the width. Compare raises all four flag enables and leaves writeEn low.
- R3: Add-with-carry adds carryIn to a + b. Subtract-with-borrow computes a - b - carryIn, and its CF is set when a < b + carryIn. The other operations ignore carryIn.
- R4: The result is zero above the selected width, and operand bits above the width have no effect. SF is result bit width-1. ZF is set when the result is zero.
- R5: And, or, xor and test produce CF = 0 and OF = 0 with all flag enables high. Test leaves writeEn low.
- R6: The shift count is b[5:0] at 64 bits and b[4:0] at the other widths. The arithmetic right shift fills with the sign bit of a at the width. Shifts raise writeEn and no flag enable.
- R7: With unaryOp high, opCode[1:0] selects 0 increment, 1 decrement, 2 not, 3 negate, and opCode[3:2] is ignored. Increment and decrement write the result and update OF, SF and ZF. They never raise cfWe.
- R8: Not writes the inverted operand a and raises no flag enable. Negate writes 0 - a, sets CF when a is nonzero at the width, and updates CF, SF and ZF but not OF.
- R9: A rotate code (8 to B, unaryOp low) raises unsupported, drives result to zero and raises no enable.
- R10: Each of cfOut, zfOut, sfOut and ofOut reads 0 whenever its own enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation code, or unary selector in bits 1:0 |
| unaryOp | input | 1 | Selects the single-operand operations |
| sizeSel | input | 2 | Operand width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| aIn | input | 64 | First operand (the only operand for unary operations) |
| bIn | input | 64 | Second operand or shift count |
| carryIn | input | 1 | Current carry flag |
| result | output | 64 | Result, zero-extended above the width |
| writeEn | output | 1 | Result is to be written back |
| cfWe | output | 1 | Carry flag update enable |
| zfWe | output | 1 | Zero flag update enable |
| sfWe | output | 1 | Sign flag update enable |
| ofWe | output | 1 | Overflow flag update enable |
| cfOut | output | 1 | New carry flag |
| zfOut | output | 1 | New zero flag |
| sfOut | output | 1 | New sign flag |
| ofOut | output | 1 | New overflow flag |
| unsupported | output | 1 | Operation code is a rotate |

## Verification
Additions and subtractions are driven at each width with operand pairs that fall just on either side of the unsigned and signed limits. These pairs separate carry from overflow, and they catch a carry or sign bit taken from the wrong width. Operands carry non-zero bits above the selected width, which exposes missing input masking. Carry-in cases pair the same operands with carryIn 0 and 1, and include the borrow case whose signed result lands exactly on the most negative value. Shift counts are chosen so that their discarded high bits would change the result if the count were masked wrongly. The unary and rotate codes are checked on their enable patterns as well as their values.

// File: rtl/aluPkg.sv
`timescale 1ns/1ps
package aluPkg;
  localparam int DW  = 64;
  localparam int SHW = $clog2(DW);
  localparam int WB  = SHW + 1;
  localparam int XW  = DW + 2;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_OR  = 4'h1, OP_ADC = 4'h2, OP_SBB = 4'h3,
    OP_AND = 4'h4, OP_SUB = 4'h5, OP_XOR = 4'h6, OP_CMP = 4'h7,
    OP_ROL = 4'h8, OP_ROR = 4'h9, OP_RCL = 4'hA, OP_RCR = 4'hB,
    OP_SHL = 4'hC, OP_SHR = 4'hD, OP_TST = 4'hE, OP_SAR = 4'hF
  } opCodeE;

  typedef enum logic [1:0] {UN_INC = 2'd0, UN_DEC = 2'd1, UN_NOT = 2'd2, UN_NEG = 2'd3} unaryE;

  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} sizeE;

  typedef enum logic [2:0] {
    SRC_ARITH, SRC_AND, SRC_OR, SRC_XOR, SRC_NOT, SRC_SHL, SRC_SHR, SRC_SAR
  } srcSelE;

  // strobes consumed by the datapath
  typedef struct packed {
    srcSelE resSel;
    logic   subtract;
    logic   useCarry;
    logic   bIsOne;
    logic   aIsZero;
  } dpCtrlS;

  // full decode: datapath strobes plus commit enables
  typedef struct packed {
    dpCtrlS dp;
    logic   writeRes;
    logic   cfWe;
    logic   zsWe;
    logic   ofWe;
    logic   unsupported;
  } ctrlS;
endpackage

// File: rtl/aluCtrl.sv
`timescale 1ns/1ps
module aluCtrl
  import aluPkg::*;
(
  input  logic [3:0] opCode,
  input  logic       unaryOp,
  output ctrlS       ctl
);
  always_comb begin
    ctl = '0;
    ctl.dp.resSel = SRC_ARITH;
    if (unaryOp) begin
      case (unaryE'(opCode[1:0]))
        UN_INC: begin
          ctl.dp.bIsOne = 1'b1;
          ctl.writeRes  = 1'b1;
          ctl.zsWe      = 1'b1;
          ctl.ofWe      = 1'b1;
        end
        UN_DEC: begin
          ctl.dp.bIsOne   = 1'b1;
          ctl.dp.subtract = 1'b1;
          ctl.writeRes    = 1'b1;
          ctl.zsWe        = 1'b1;
          ctl.ofWe        = 1'b1;
        end
        UN_NOT: begin
          ctl.dp.resSel = SRC_NOT;
          ctl.writeRes  = 1'b1;
        end
        default: begin
          ctl.dp.aIsZero  = 1'b1;
          ctl.dp.subtract = 1'b1;
          ctl.writeRes    = 1'b1;
          ctl.cfWe        = 1'b1;
          ctl.zsWe        = 1'b1;
        end
      endcase
    end else begin
      case (opCodeE'(opCode))
        OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
          ctl.dp.subtract = (opCode == OP_SUB) || (opCode == OP_SBB) || (opCode == OP_CMP);
          ctl.dp.useCarry = (opCode == OP_ADC) || (opCode == OP_SBB);
          ctl.writeRes    = (opCode != OP_CMP);
          ctl.cfWe        = 1'b1;
          ctl.zsWe        = 1'b1;
          ctl.ofWe        = 1'b1;
        end
        OP_AND, OP_OR, OP_XOR, OP_TST: begin
          ctl.dp.resSel = (opCode == OP_OR)  ? SRC_OR  :
                          (opCode == OP_XOR) ? SRC_XOR : SRC_AND;
          ctl.writeRes  = (opCode != OP_TST);
          ctl.cfWe      = 1'b1;
          ctl.zsWe      = 1'b1;
          ctl.ofWe      = 1'b1;
        end
        OP_SHL: begin
          ctl.dp.resSel = SRC_SHL;
          ctl.writeRes  = 1'b1;
        end
        OP_SHR: begin
          ctl.dp.resSel = SRC_SHR;
          ctl.writeRes  = 1'b1;
        end
        OP_SAR: begin
          ctl.dp.resSel = SRC_SAR;
          ctl.writeRes  = 1'b1;
        end
        default: ctl.unsupported = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/aluDatapath.sv
`timescale 1ns/1ps
module aluDatapath
  import aluPkg::*;
(
  input  dpCtrlS          dpCtl,
  input  logic [1:0]      sizeSel,
  input  logic [DW-1:0]   aIn,
  input  logic [DW-1:0]   bIn,
  input  logic            carryIn,
  output logic [DW-1:0]   resVal,
  output logic            cfVal,
  output logic            zfVal,
  output logic            sfVal,
  output logic            ofVal
);
  logic [WB-1:0]  wBits;
  logic [SHW-1:0] sgnIdx;
  logic [DW-1:0]  widthMask, aM, bM, opA, opB, aSar, rawRes;
  logic [XW-1:0]  aSx, bSx, uSum, sSum;
  logic [SHW-1:0] cnt;
  logic           cin, carryBit, ovfBit;

  // width geometry
  always_comb begin
    wBits     = WB'(8) << sizeSel;
    sgnIdx    = (WB-1)'(wBits - WB'(1));
    widthMask = {DW{1'b1}} >> (WB'(DW) - wBits);
    aM        = aIn & widthMask;
    bM        = bIn & widthMask;
  end

  // adder operands, zero- and sign-extended sums
  always_comb begin
    opA = dpCtl.aIsZero ? '0 : aM;
    opB = dpCtl.aIsZero ? aM : (dpCtl.bIsOne ? DW'(1) : bM);
    cin = dpCtl.useCarry & carryIn;
    aSx = XW'(opA) | (opA[sgnIdx] ? ~XW'(widthMask) : '0);
    bSx = XW'(opB) | (opB[sgnIdx] ? ~XW'(widthMask) : '0);
    if (dpCtl.subtract) begin
      uSum = XW'(opA) - XW'(opB) - XW'(cin);
      sSum = aSx - bSx - XW'(cin);
    end else begin
      uSum = XW'(opA) + XW'(opB) + XW'(cin);
      sSum = aSx + bSx + XW'(cin);
    end
    carryBit = uSum[wBits];
    ovfBit   = sSum[wBits] ^ sSum[{1'b0, sgnIdx}];
  end

  // shifter
  always_comb begin
    cnt  = (sizeSel == SZ64) ? bIn[SHW-1:0] : {1'b0, bIn[SHW-2:0]};
    aSar = aM | (aM[sgnIdx] ? ~widthMask : '0);
  end

  // result select and flags
  always_comb begin
    case (dpCtl.resSel)
      SRC_AND: rawRes = aM & bM;
      SRC_OR:  rawRes = aM | bM;
      SRC_XOR: rawRes = aM ^ bM;
      SRC_NOT: rawRes = ~aM;
      SRC_SHL: rawRes = aM << cnt;
      SRC_SHR: rawRes = aM >> cnt;
      SRC_SAR: rawRes = DW'($signed(aSar) >>> cnt);
      default: rawRes = uSum[DW-1:0];
    endcase
    resVal = rawRes & widthMask;
    zfVal  = (resVal == '0);
    sfVal  = resVal[sgnIdx];
    cfVal  = (dpCtl.resSel == SRC_ARITH) ? carryBit : 1'b0;
    ofVal  = (dpCtl.resSel == SRC_ARITH) ? ovfBit   : 1'b0;
  end
endmodule

// File: rtl/flagAlu.sv
`timescale 1ns/1ps
module flagAlu
  import aluPkg::*;
(
  input  logic [3:0]    opCode,
  input  logic          unaryOp,
  input  logic [1:0]    sizeSel,
  input  logic [DW-1:0] aIn,
  input  logic [DW-1:0] bIn,
  input  logic          carryIn,
  output logic [DW-1:0] result,
  output logic          writeEn,
  output logic          cfWe,
  output logic          zfWe,
  output logic          sfWe,
  output logic          ofWe,
  output logic          cfOut,
  output logic          zfOut,
  output logic          sfOut,
  output logic          ofOut,
  output logic          unsupported
);
  ctrlS          ctl;
  logic [DW-1:0] dpRes;
  logic          cfVal, zfVal, sfVal, ofVal;

  aluCtrl uCtrl (
    .opCode (opCode),
    .unaryOp(unaryOp),
    .ctl    (ctl)
  );

  aluDatapath uDp (
    .dpCtl  (ctl.dp),
    .sizeSel(sizeSel),
    .aIn    (aIn),
    .bIn    (bIn),
    .carryIn(carryIn),
    .resVal (dpRes),
    .cfVal  (cfVal),
    .zfVal  (zfVal),
    .sfVal  (sfVal),
    .ofVal  (ofVal)
  );

  always_comb begin
    unsupported = ctl.unsupported;
    result      = ctl.unsupported ? '0 : dpRes;
    writeEn     = ctl.writeRes;
    cfWe        = ctl.cfWe;
    zfWe        = ctl.zsWe;
    sfWe        = ctl.zsWe;
    ofWe        = ctl.ofWe;
    cfOut       = ctl.cfWe & cfVal;
    zfOut       = ctl.zsWe & zfVal;
    sfOut       = ctl.zsWe & sfVal;
    ofOut       = ctl.ofWe & ofVal;
  end
endmodule

// File: rtl/flagAluChecker.sv
`timescale 1ns/1ps
module flagAluChecker (
  input logic [3:0]  opCode,
  input logic        unaryOp,
  input logic [1:0]  sizeSel,
  input logic [63:0] result,
  input logic        writeEn,
  input logic        cfWe,
  input logic        zfWe,
  input logic        sfWe,
  input logic        ofWe,
  input logic        cfOut,
  input logic        zfOut,
  input logic        sfOut,
  input logic        ofOut,
  input logic        unsupported
);
  logic isRot, isShift, isLogic, isIncDec;

  always_comb begin
    isRot    = !unaryOp && (opCode[3:2] == 2'b10);
    isShift  = !unaryOp && (opCode == 4'hC || opCode == 4'hD || opCode == 4'hF);
    isLogic  = !unaryOp && (opCode == 4'h1 || opCode == 4'h4 || opCode == 4'h6 || opCode == 4'hE);
    isIncDec = unaryOp && !opCode[1];

    // R9: rotate codes commit nothing
    a_r9_rotate_quiet: assert (!isRot || (unsupported && !writeEn && !cfWe && !zfWe && !sfWe && !ofWe && result == '0))
      else $error("rotate code committed state");
    // R6: shifts touch no flag
    a_r6_shift_noflags: assert (!isShift || (writeEn && !cfWe && !zfWe && !sfWe && !ofWe))
      else $error("shift raised a flag enable");
    // R7: increment/decrement keep carry
    a_r7_incdec_keep_cf: assert (!isIncDec || (!cfWe && zfWe && sfWe && ofWe && writeEn))
      else $error("inc/dec enable pattern wrong");
    // R5: logical ops clear CF and OF
    a_r5_logic_clear: assert (!isLogic || (cfWe && ofWe && !cfOut && !ofOut))
      else $error("logical op left CF or OF set");
    // R4: nothing above the selected width
    a_r4_upper_zero: assert (sizeSel == 2'd3 || (result >> (7'd8 << sizeSel)) == '0)
      else $error("result bits above width");
    // R10: flag values gated by their enables
    a_r10_gated_flags: assert ((cfWe || !cfOut) && (zfWe || !zfOut) && (sfWe || !sfOut) && (ofWe || !ofOut))
      else $error("flag value without enable");
    // R2: compare writes only flags
    a_r2_cmp_nowrite: assert (unaryOp || opCode != 4'h7 || (!writeEn && cfWe && ofWe))
      else $error("compare wrote result");
  end
endmodule

bind flagAlu flagAluChecker uChk (
  .opCode     (opCode),
  .unaryOp    (unaryOp),
  .sizeSel    (sizeSel),
  .result     (result),
  .writeEn    (writeEn),
  .cfWe       (cfWe),
  .zfWe       (zfWe),
  .sfWe       (sfWe),
  .ofWe       (ofWe),
  .cfOut      (cfOut),
  .zfOut      (zfOut),
  .sfOut      (sfOut),
  .ofOut      (ofOut),
  .unsupported(unsupported)
);

// File: tb/flagAlu_test.sv
`timescale 1ns/1ps
module flagAlu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = '0;
  logic        unaryOp = 1'b0;
  logic [1:0]  sizeSel = '0;
  logic [63:0] aIn = '0, bIn = '0;
  logic        carryIn = 1'b0;
  logic [63:0] result;
  logic        writeEn, cfWe, zfWe, sfWe, ofWe, cfOut, zfOut, sfOut, ofOut, unsupported;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic [9:0]  ctl;  // {unsupported, writeEn, cfWe, zfWe, sfWe, ofWe, cf, zf, sf, of}
    string       tag;
  } expT;
  expT expQ[$];

  always #2.5 clk = ~clk;

  flagAlu uut (
    .opCode(opCode), .unaryOp(unaryOp), .sizeSel(sizeSel),
    .aIn(aIn), .bIn(bIn), .carryIn(carryIn),
    .result(result), .writeEn(writeEn),
    .cfWe(cfWe), .zfWe(zfWe), .sfWe(sfWe), .ofWe(ofWe),
    .cfOut(cfOut), .zfOut(zfOut), .sfOut(sfOut), .ofOut(ofOut),
    .unsupported(unsupported)
  );

  // driver: apply on falling edge, queue expectation
  task automatic drive(input logic [3:0] op, input logic un, input logic [1:0] sz,
                       input logic [63:0] a, input logic [63:0] b, input logic c,
                       input logic [63:0] expRes, input logic [9:0] expCtl, input string tag);
    expT item;
    @(negedge clk);
    opCode = op; unaryOp = un; sizeSel = sz; aIn = a; bIn = b; carryIn = c;
    item.res = expRes; item.ctl = expCtl; item.tag = tag;
    expQ.push_back(item);
  endtask

  // monitor: compare on the following rising edge
  always @(posedge clk) begin
    if (expQ.size() > 0) begin
      automatic expT item = expQ.pop_front();
      automatic logic [9:0] got = {unsupported, writeEn, cfWe, zfWe, sfWe, ofWe,
                                   cfOut, zfOut, sfOut, ofOut};
      checks++;
      if (result !== item.res || got !== item.ctl) begin
        fails++;
        $display("FAIL %s: result=%h ctl=%b expected result=%h ctl=%b",
                 item.tag, result, got, item.res, item.ctl);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R4 quiescent state: add of zeros
    drive(4'h0, 0, 2'd0, 64'h0, 64'h0, 0, 64'h0, 10'b0_1_1111_0100, "R4 idle zero");
    // R1 add at widths
    drive(4'h0, 0, 2'd0, 64'hFF, 64'h01, 0, 64'h0, 10'b0_1_1111_1100, "R1 add8 carry");
    drive(4'h0, 0, 2'd0, 64'hFFFF_FFFF_FFFF_FF7F, 64'hFF00_0000_0000_0001, 0, 64'h80, 10'b0_1_1111_0011, "R1/R4 add8 overflow upper junk");
    drive(4'h0, 0, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, 64'h8000_0000_0000_0000, 10'b0_1_1111_0011, "R1 add64 overflow");
    drive(4'h0, 0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 0, 64'h1, 10'b0_1_1111_1000, "R1 add64 carry");
    drive(4'h0, 0, 2'd1, 64'h8000, 64'h8000, 0, 64'h0, 10'b0_1_1111_1101, "R1 add16 carry+overflow");
    // R2 subtract / compare
    drive(4'h5, 0, 2'd1, 64'h1, 64'h2, 0, 64'hFFFF, 10'b0_1_1111_1010, "R2 sub16 borrow");
    drive(4'h5, 0, 2'd2, 64'h8000_0000, 64'h1, 0, 64'h7FFF_FFFF, 10'b0_1_1111_0001, "R2 sub32 overflow");
    drive(4'h7, 0, 2'd0, 64'h5, 64'h5, 0, 64'h0, 10'b0_0_1111_0100, "R2 cmp equal");
    drive(4'h7, 0, 2'd0, 64'h3, 64'h5, 0, 64'hFE, 10'b0_0_1111_1010, "R2 cmp below");
    // R3 carry in
    drive(4'h2, 0, 2'd0, 64'hFF, 64'h0, 1, 64'h0, 10'b0_1_1111_1100, "R3 adc cin=1");
    drive(4'h2, 0, 2'd0, 64'hFF, 64'h0, 0, 64'hFF, 10'b0_1_1111_0010, "R3 adc cin=0");
    drive(4'h3, 0, 2'd0, 64'h0, 64'h7F, 1, 64'h80, 10'b0_1_1111_1010, "R3 sbb to most negative");
    drive(4'h3, 0, 2'd2, 64'h5, 64'h3, 1, 64'h1, 10'b0_1_1111_0000, "R3 sbb32");
    drive(4'h0, 0, 2'd0, 64'h1, 64'h1, 1, 64'h2, 10'b0_1_1111_0000, "R3 add ignores cin");
    // R5 logical
    drive(4'h4, 0, 2'd2, 64'hF0F0_F0F0, 64'h0FF0_0000, 0, 64'h00F0_0000, 10'b0_1_1111_0000, "R5 and32");
    drive(4'h1, 0, 2'd1, 64'h8000, 64'h0001, 0, 64'h8001, 10'b0_1_1111_0010, "R5 or16");
    drive(4'h6, 0, 2'd3, 64'h1234, 64'h1234, 0, 64'h0, 10'b0_1_1111_0100, "R5 xor64");
    drive(4'hE, 0, 2'd0, 64'h80, 64'h80, 1, 64'h80, 10'b0_0_1111_0010, "R5 test no write");
    // R6 shifts
    drive(4'hC, 0, 2'd0, 64'h81, 64'h21, 0, 64'h02, 10'b0_1_0000_0000, "R6 shl8 count mask");
    drive(4'hC, 0, 2'd2, 64'h1, 64'h3F, 0, 64'h8000_0000, 10'b0_1_0000_0000, "R6 shl32 count31");
    drive(4'hC, 0, 2'd3, 64'h1, 64'h3F, 0, 64'h8000_0000_0000_0000, 10'b0_1_0000_0000, "R6/R10 shl64 count63");
    drive(4'hC, 0, 2'd2, 64'h1, 64'h20, 0, 64'h1, 10'b0_1_0000_0000, "R6 shl32 count masked to 0");
    drive(4'hD, 0, 2'd1, 64'h8000, 64'h0F, 0, 64'h1, 10'b0_1_0000_0000, "R6 shr16");
    drive(4'hD, 0, 2'd3, 64'h8000_0000_0000_0000, 64'h7F, 0, 64'h1, 10'b0_1_0000_0000, "R6 shr64 six-bit count");
    drive(4'hF, 0, 2'd0, 64'h80, 64'h3, 0, 64'hF0, 10'b0_1_0000_0000, "R6 sar8 fill");
    drive(4'hF, 0, 2'd0, 64'h80, 64'h1F, 0, 64'hFF, 10'b0_1_0000_0000, "R6 sar8 count31");
    drive(4'hF, 0, 2'd2, 64'h4000_0000, 64'h1, 0, 64'h2000_0000, 10'b0_1_0000_0000, "R6 sar32 positive");
    drive(4'hF, 0, 2'd3, 64'h8000_0000_0000_0000, 64'h3F, 0, 64'hFFFF_FFFF_FFFF_FFFF, 10'b0_1_0000_0000, "R6 sar64");
    // R7 increment / decrement
    drive(4'h0, 1, 2'd0, 64'h7F, 64'h0, 0, 64'h80, 10'b0_1_0111_0011, "R7 inc8 overflow");
    drive(4'h8, 1, 2'd0, 64'hFF, 64'h0, 1, 64'h0, 10'b0_1_0111_0100, "R7 inc wraps, upper code ignored");
    drive(4'h1, 1, 2'd1, 64'h8000, 64'h0, 0, 64'h7FFF, 10'b0_1_0111_0001, "R7 dec16 overflow");
    drive(4'h1, 1, 2'd1, 64'h0, 64'h0, 0, 64'hFFFF, 10'b0_1_0111_0010, "R7 dec16 wrap");
    // R8 not / negate
    drive(4'h2, 1, 2'd2, 64'h0000_FFFF, 64'h0, 0, 64'hFFFF_0000, 10'b0_1_0000_0000, "R8 not32");
    drive(4'h3, 1, 2'd0, 64'h01, 64'h0, 0, 64'hFF, 10'b0_1_1110_1010, "R8 neg8 one");
    drive(4'h3, 1, 2'd0, 64'h00, 64'h0, 0, 64'h00, 10'b0_1_1110_0100, "R8 neg8 zero");
    drive(4'h3, 1, 2'd0, 64'h80, 64'h0, 0, 64'h80, 10'b0_1_1110_1010, "R8/R10 neg8 most negative");
    drive(4'h3, 1, 2'd3, 64'h1, 64'h0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 10'b0_1_1110_1010, "R8 neg64");
    // R9 rotates
    for (int k = 8; k < 12; k++)
      drive(4'(k), 0, 2'd3, 64'h5, 64'h1, 1, 64'h0, 10'b1_0_0000_0000, "R9 rotate unsupported");
    @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule